// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a synchronous on-chip request port and an external asynchronous static RAM of 256K one-byte words. A requester presents an 18-bit address, a direction flag and, for writes, one data byte, using a valid/ready handshake. The controller then drives the memory's two chip enables, write enable, output enable and address. It also drives a data bus that is split into an output value, an output enable and an input value. The strobe sequence honours every nanosecond minimum of the memory. Each minimum is turned into a whole number of clock cycles from a clock-period parameter. The count rounds up and is never less than one.

A read selects the chip and opens the memory's outputs. It holds that state for the read time and captures the byte on the last clock edge. The byte comes back with a one-cycle valid pulse. A write keeps the memory's outputs closed and pulls write enable low. It waits for the memory to release the bus before it drives data, then raises write enable once the pulse width, address setup and data setup are all covered. The data stays driven for one more cycle and a short recovery completes the write cycle time. Between operations the chip is always deselected for at least one cycle, so the memory rests in standby and the bus changes direction with no contention.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset and whenever no operation is in progress, the controller holds `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `req_ready`=1, and `rd_valid` stays 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1 (`req_write`=1 for a write, 0 for a read). `req_ready` is 0 from the cycle after acceptance until the operation has ended.
- R3: A read keeps `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly ceil(70 ns / period) cycles, which is 14 at 5 ns. The controller does not drive the bus during a read.
- R4: The read byte is sampled from `mem_dq_in` on the edge that ends the last read cycle. It appears on `rd_data` with `rd_valid`=1 for one cycle only, 14 cycles after the accepting edge at 5 ns, and that cycle is an idle cycle.
- R5: A write holds `mem_oe_n`=1 throughout. It keeps `mem_we_n`=0 with the chip selected for max(ceil(50/T), ceil(60/T), ceil(25/T)+ceil(30/T)) consecutive cycles, which is 12 at 5 ns.
- R6: During a write, `mem_dq_oe` is 0 for the first ceil(25/T) cycles (5) of the write-enable-low period and 1 for the rest (7 cycles, at least ceil(30/T)). It is still 1 in the first cycle after `mem_we_n` returns high and 0 in the cycle after that. `mem_dq_out` carries the request byte while driven.
- R7: A write keeps the chip selected for ceil(70/T) cycles in total (14 at 5 ns), with `mem_we_n`=1 for at least the last cycle. The controller then returns to idle.
- R8: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0.
- R9: `mem_addr` equals the accepted request address for the whole of an operation and does not change while the chip stays selected.
- R10: A write never produces a `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | One-cycle pulse: read byte on rd_data |
| rd_data | output | 8 | Captured read byte |
| mem_addr | output | 18 | Memory address lines |
| mem_ce1_n | output | 1 | Memory chip enable, active low |
| mem_ce2 | output | 1 | Memory chip enable, active high |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The read-data pulse of one operation falls in the same idle cycle as the acceptance of the next request. So the return path and the start of a new strobe sequence share a clock edge. The bench provokes this by presenting the next request while the controller is busy. Reads are mixed with writes to the same address, so each request waits and is taken on that edge. The scoreboard judges the returned byte and its exact cycle. The memory model checks that the next operation's pins, address and turnaround start one cycle later with no overlap.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_READ = 2'd1,
    PH_WLOW = 2'd2,
    PH_WREC = 2'd3
  } phase_t;

  // Rounds a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int N_RD   = 14,
  parameter int N_WLOW = 12,
  parameter int N_WREC = 2,
  parameter int CW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output phase_t        phase,
  output logic [CW-1:0] cnt,
  output logic          acc_evt,
  output logic          rd_cap_evt
);

  phase_t        phase_nx;
  logic [CW-1:0] limit;
  logic          last;

  always_comb begin
    unique case (phase)
      PH_READ: limit = CW'(N_RD);
      PH_WLOW: limit = CW'(N_WLOW);
      PH_WREC: limit = CW'(N_WREC);
      default: limit = CW'(1);
    endcase
  end

  assign last       = (cnt == limit - CW'(1));
  assign acc_evt    = (phase == PH_IDLE) && req_valid;
  assign rd_cap_evt = (phase == PH_READ) && last;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: if (acc_evt) phase_nx = req_write ? PH_WLOW : PH_READ;
      PH_READ: if (last)    phase_nx = PH_IDLE;
      PH_WLOW: if (last)    phase_nx = PH_WREC;
      PH_WREC: if (last)    phase_nx = PH_IDLE;
      default:              phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_nx;
      if (phase_nx != phase || phase == PH_IDLE) cnt <= '0;
      else                                       cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctl_pkg::*;
#(
  parameter int N_TURN = 5,
  parameter int CW     = 4
) (
  input  phase_t        phase,
  input  logic [CW-1:0] cnt,
  output logic          req_ready,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_dq_oe
);

  logic sel;
  logic drive_wlow;
  logic drive_hold;

  assign sel        = (phase != PH_IDLE);
  assign req_ready  = !sel;
  assign mem_ce1_n  = !sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = (phase != PH_WLOW);
  assign mem_oe_n   = (phase != PH_READ);

  // Drivers open once the memory has had time to float its outputs,
  // and stay open for the first cycle after write enable rises.
  assign drive_wlow = (phase == PH_WLOW) && (cnt >= CW'(N_TURN));
  assign drive_hold = (phase == PH_WREC) && (cnt == '0);
  assign mem_dq_oe  = drive_wlow || drive_hold;

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_evt,
  input  logic          rd_cap_evt,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= rd_cap_evt;
      if (acc_evt) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (rd_cap_evt) rd_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_DOE_NS  = 35,
  parameter int T_WC_NS   = 70,
  parameter int T_PWE_NS  = 50,
  parameter int T_AW_NS   = 60,
  parameter int T_SD_NS   = 30,
  parameter int T_HZ_NS   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int N_RD   = ns_to_cycles(max3(T_RC_NS, T_AA_NS, T_DOE_NS), CLK_NS);
  localparam int N_TURN = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int N_SD   = ns_to_cycles(T_SD_NS, CLK_NS);
  localparam int N_WLOW = max3(ns_to_cycles(T_PWE_NS, CLK_NS),
                               ns_to_cycles(T_AW_NS, CLK_NS),
                               N_TURN + N_SD);
  localparam int N_WC   = ns_to_cycles(T_WC_NS, CLK_NS);
  localparam int N_WREC = max2(1, N_WC - N_WLOW);
  localparam int N_MAX  = max3(N_RD, N_WLOW, N_WREC);
  localparam int CW     = $clog2(N_MAX + 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          acc_evt;
  logic          rd_cap_evt;

  sram_seq #(
    .N_RD   (N_RD),
    .N_WLOW (N_WLOW),
    .N_WREC (N_WREC),
    .CW     (CW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .phase      (phase),
    .cnt        (cnt),
    .acc_evt    (acc_evt),
    .rd_cap_evt (rd_cap_evt)
  );

  sram_pins #(
    .N_TURN (N_TURN),
    .CW     (CW)
  ) u_pins (
    .phase     (phase),
    .cnt       (cnt),
    .req_ready (req_ready),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_dpath #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_evt    (acc_evt),
    .rd_cap_evt (rd_cap_evt),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int AW     = 18,
  parameter int N_TURN = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce1_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic          acc_evt,
  input logic          rd_cap_evt
);

  // Cycles spent with write enable low so far in the current pulse.
  logic [15:0] wl_age;
  always_ff @(posedge clk) begin
    if (!rst_n)         wl_age <= '0;
    else if (!mem_we_n) wl_age <= (wl_age == 16'hFFFF) ? wl_age : wl_age + 16'd1;
    else                wl_age <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> (!req_ready && !mem_ce1_n));

  p_read_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce1_n && mem_ce2 && mem_we_n));

  p_capture_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cap_evt |-> !mem_oe_n);

  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (req_ready && $past(!mem_oe_n)));

  p_rvalid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_write_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce1_n && mem_ce2));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && mem_dq_oe) |-> (int'(wl_age) >= N_TURN));

  p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce1_n) ##1 !mem_dq_oe);

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .AW     (ADDR_W),
  .N_TURN (N_TURN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .mem_addr   (mem_addr),
  .mem_ce1_n  (mem_ce1_n),
  .mem_ce2    (mem_ce2),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe),
  .acc_evt    (acc_evt),
  .rd_cap_evt (rd_cap_evt)
);

// File: tb/tb_sram_async_ctl.sv
module tb_sram_async_ctl;

  // Expected counts at a 5 ns period, from the requirement text.
  localparam int E_RD   = 14;  // R3: 70/5
  localparam int E_WLOW = 12;  // R5: max(10, 12, 5+6)
  localparam int E_TURN = 5;   // R6: 25/5
  localparam int E_DRV  = 7;   // R6: E_WLOW - E_TURN
  localparam int E_SEL  = 14;  // R3 / R7: chip selected span

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [17:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #2.5 clk = ~clk;

  sram_async_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit active = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory contents: untouched locations hold a value derived from the address.
  logic [7:0] mem     [int];
  logic [7:0] ref_mem [int];

  function automatic logic [7:0] fill(input int a);
    return 8'(a ^ (a >> 8) ^ 8'h21);
  endfunction

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : fill(a);
  endfunction

  function automatic logic [7:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : fill(a);
  endfunction

  typedef struct {
    logic [7:0] data;
    int         acc;
  } exp_t;
  exp_t sb_q[$];

  logic [17:0] cur_addr = '0;

  // Driver: presents a request at once, keeps it up until it is taken.
  task automatic issue(input bit wr, input int a, input logic [7:0] d);
    bit rdy;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 18'(a);
    req_wdata = d;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      #1;
      if (rdy) break;
    end
    req_valid = 1'b0;
    cur_addr  = 18'(a);
    if (wr) ref_mem[a] = d;
    else begin
      e.data = ref_rd(a);
      e.acc  = cyc;
      sb_q.push_back(e);
    end
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 ready drops after accept", int'(req_ready), 0);
  endtask

  // Monitor: scoreboard for returned bytes.
  always @(negedge clk) begin
    if (active && rd_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 rd_valid with no read pending", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rd_data == e.data, "R4 read data", int'(rd_data), int'(e.data));
        chk(cyc == e.acc + E_RD, "R4 rd_valid cycle", cyc - e.acc, E_RD);
        chk(req_ready == 1'b1, "R4 rd_valid in idle cycle", int'(req_ready), 1);
      end
    end
  end

  // Memory model and pin checks.
  int rd_age = 0;
  logic [17:0] addr_q = '0;
  int wlow = 0, drv = 0, sel_run = 0;
  bit wr_prev = 1'b0, post = 1'b0, saw_wr = 1'b0;

  always @(negedge clk) begin
    bit rd_cond, wr_cond, sel;
    sel     = !mem_ce1_n;
    rd_cond = sel && mem_ce2 && !mem_oe_n && mem_we_n;
    wr_cond = sel && mem_ce2 && !mem_we_n;

    // Data is valid only once address and strobes have been steady ~70 ns.
    if (rd_cond && rd_age > 0 && mem_addr == addr_q) rd_age++;
    else rd_age = rd_cond ? 1 : 0;
    addr_q    = mem_addr;
    mem_dq_in = (rd_cond && rd_age >= E_RD) ? mem_rd(int'(mem_addr)) : 8'hEE;

    if (active) begin
      chk(!(mem_dq_oe && !mem_oe_n), "R8 no contention", int'(mem_dq_oe), 0);
      chk(mem_ce2 == sel, "R1 enables agree", int'(mem_ce2), int'(sel));
      if (req_ready)
        chk(!sel && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle pins",
            {mem_ce1_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      if (sel) chk(mem_addr == cur_addr, "R9 address", int'(mem_addr), int'(cur_addr));
      if (rd_cond) chk(!mem_dq_oe, "R3 no drive on read", int'(mem_dq_oe), 0);

      if (wr_cond) begin
        wlow++;
        saw_wr = 1'b1;
        chk(mem_oe_n, "R5 oe high in write", int'(mem_oe_n), 1);
        if (wlow <= E_TURN) chk(!mem_dq_oe, "R6 turnaround", int'(mem_dq_oe), 0);
        else chk(mem_dq_oe, "R6 drive after turnaround", int'(mem_dq_oe), 1);
        if (mem_dq_oe) drv++;
      end else if (wr_prev) begin
        chk(wlow == E_WLOW, "R5 we low length", wlow, E_WLOW);
        chk(drv == E_DRV, "R6 data setup cycles", drv, E_DRV);
        chk(mem_dq_oe && sel, "R6 hold after we rises", int'(mem_dq_oe), 1);
        mem[int'(mem_addr)] = mem_dq_out;
        wlow = 0;
        drv  = 0;
        post = 1'b1;
      end else if (post) begin
        chk(!mem_dq_oe, "R6 release", int'(mem_dq_oe), 0);
        post = 1'b0;
      end
      wr_prev = wr_cond;

      if (sel) sel_run++;
      else if (sel_run != 0) begin
        chk(sel_run == E_SEL, saw_wr ? "R7 write span" : "R3 read span", sel_run, E_SEL);
        sel_run = 0;
        saw_wr  = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rd_valid,
        "R1 reset state", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rd_valid},
        7'b1011010);
    rst_n = 1'b1;
    active = 1'b1;
    repeat (3) @(negedge clk);

    issue(1'b1, 18'h00A5A, 8'h3C);         // R5 R6 R7
    issue(1'b0, 18'h00A5A, 8'h00);         // R3 R4 read-after-write
    issue(1'b0, 18'h12345, 8'h00);         // R4 untouched location
    issue(1'b1, 18'h00000, 8'h81);         // lowest address
    issue(1'b1, 18'h3FFFF, 8'h7E);         // highest address
    issue(1'b0, 18'h00000, 8'h00);
    issue(1'b0, 18'h3FFFF, 8'h00);
    issue(1'b1, 18'h00A5A, 8'hC3);         // overwrite
    issue(1'b0, 18'h00A5A, 8'h00);
    issue(1'b0, 18'h00A5A, 8'h00);         // back-to-back reads
    repeat (10) @(negedge clk);            // R1 idle stretch
    for (int i = 0; i < 24; i++) begin
      int a;
      a = (i * 18'h0B3D1 + 18'h00777) & 18'h3FFFF;
      issue(i[0], (i[0] ? a : ((i - 1) * 18'h0B3D1 + 18'h00777) & 18'h3FFFF),
            8'(i * 37 + 5));
    end
    issue(1'b1, 18'h15555, 8'h00);
    issue(1'b0, 18'h15555, 8'h00);

    repeat (40) @(negedge clk);
    chk(sb_q.size() == 0, "R4 all reads returned", sb_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule